// File: doc/BRIEF.md
# Integer Logic Execution Unit

This block executes one already-decoded integer instruction per clock cycle against a bank of 32 general-purpose registers, each 32 bits wide. Every instruction carries an operation code, a destination index, two source indices, a 16-bit immediate field and a 5-bit shift amount. The two sources are read combinationally and pass through immediate shaping and an adder/logic/shift unit. The result appears on the `result` output in the same cycle. It is written to the destination register at the next rising clock edge when write enable is high.

The operation set covers wrapping add and subtract, add with a signed immediate, and the bitwise AND, OR, NOR and XOR. AND, OR and XOR also come in immediate forms that take an unsigned bit pattern. There are logical shifts in both directions and an upper-half constant load. Register 0 is a constant zero. Inversion is done with NOR against register 0 or XOR against an all-ones register. A full 32-bit constant is built with the upper-half load followed by an OR-immediate. Fetch, binary decode, memory access, branching and overflow traps are handled by surrounding logic.

Top module: `int_logic_exu`

## Requirements
- R1: A synchronous active-high `rst` clears all registers to zero; afterwards every register reads as zero.
- R2: Register 0 always reads as zero; a write with `dst_idx` 0 is discarded.
- R3: `op_code` 0 (add) gives srcA + srcB and `op_code` 1 (subtract) gives srcA - srcB, both wrapping modulo 2^32 with no flag.
- R4: `op_code` 2 (add-immediate) adds srcA to `imm16` sign-extended to 32 bits, so fields 0x8000 to 0xFFFF act as -32768 to -1.
- R5: `op_code` 3, 4, 5 and 6 give srcA AND, OR, NOR and XOR srcB bit by bit; NOR with register 0 or XOR with an all-ones register inverts srcA.
- R6: `op_code` 7, 8 and 9 give srcA AND, OR and XOR `imm16` zero-extended to 32 bits.
- R7: `op_code` 10 shifts srcA left and `op_code` 11 shifts srcA right by the unsigned `shamt` (0 to 31), filling vacated bits with zeros.
- R8: `op_code` 12 (upper load) yields `imm16` in bits 31:16 with bits 15:0 cleared; an OR-immediate to the same register then completes any 32-bit constant.
- R9: With `wr_en` low, no register changes.
- R10: `result` reflects the current inputs in the same cycle; a write lands at the next rising edge, so a source equal to the destination reads the old value in that cycle and the new value in the next.
- R11: `op_code` 13 to 15 are reserved: `result` is zero and no register is written, even with `wr_en` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the register bank |
| wr_en | input | 1 | Enables write-back of the current result |
| op_code | input | 4 | Operation select (codes listed in the requirements) |
| dst_idx | input | 5 | Destination register index |
| src_a_idx | input | 5 | First source register index |
| src_b_idx | input | 5 | Second source register index |
| imm16 | input | 16 | Immediate field |
| shamt | input | 5 | Shift amount |
| result | output | 32 | Combinational result of the current instruction |

## Verification
`result` is combinational, so it is due in the same cycle as its inputs. The bench drives each instruction on the falling edge and samples `result` 2 ns later, well before the next rising edge. A register write is due one rising edge after the instruction that made it. So every write is observed by a later vector that names the written register as a source, never by the vector that wrote it. Vectors that reuse the destination as a source show the old value in the writing cycle and the new value one cycle later. Writes that must not happen (index 0, write enable low, reserved codes) are checked by reading the target register back through an OR with register 0 in the following cycle.

// File: rtl/exu_pkg.sv
package exu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_ADDI = 4'd2,
    OP_AND  = 4'd3,
    OP_OR   = 4'd4,
    OP_NOR  = 4'd5,
    OP_XOR  = 4'd6,
    OP_ANDI = 4'd7,
    OP_ORI  = 4'd8,
    OP_XORI = 4'd9,
    OP_SLL  = 4'd10,
    OP_SRL  = 4'd11,
    OP_LUI  = 4'd12
  } op_e;

  localparam logic [3:0] LAST_LEGAL_OP = 4'd12;

  function automatic logic op_is_legal(input logic [3:0] code);
    return code <= LAST_LEGAL_OP;
  endfunction

endpackage

// File: rtl/exu_regfile.sv
module exu_regfile #(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 32,
  localparam int IDX_W   = $clog2(NUM_REGS),
  localparam int N_RD    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  wa,
  input  logic [DATA_W-1:0] wd,
  input  logic [IDX_W-1:0]  ra [N_RD],
  output logic [DATA_W-1:0] rd [N_RD]
);

  logic [DATA_W-1:0] bank [NUM_REGS];

  // Entry 0 is never loaded; every other entry takes the write data on a match.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) bank[i] <= '0;
    end else if (we) begin
      for (int i = 1; i < NUM_REGS; i++)
        if (wa == IDX_W'(i)) bank[i] <= wd;
    end
  end

  // Read ports: index 0 is forced to zero independently of storage.
  for (genvar p = 0; p < N_RD; p++) begin : g_rd
    assign rd[p] = (ra[p] == '0) ? '0 : bank[ra[p]];
  end

endmodule

// File: rtl/exu_operand.sv
module exu_operand #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  exu_pkg::op_e      op,
  input  logic [DATA_W-1:0] src_b,
  input  logic [IMM_W-1:0]  imm,
  output logic [DATA_W-1:0] opnd_b
);
  import exu_pkg::*;

  function automatic logic [DATA_W-1:0] sign_ext(input logic [IMM_W-1:0] v);
    return {{(DATA_W-IMM_W){v[IMM_W-1]}}, v};
  endfunction

  function automatic logic [DATA_W-1:0] zero_ext(input logic [IMM_W-1:0] v);
    return {{(DATA_W-IMM_W){1'b0}}, v};
  endfunction

  always_comb begin
    case (op)
      OP_ADDI:                  opnd_b = sign_ext(imm);
      OP_ANDI, OP_ORI, OP_XORI: opnd_b = zero_ext(imm);
      default:                  opnd_b = src_b;
    endcase
  end

endmodule

// File: rtl/exu_alu.sv
module exu_alu #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  exu_pkg::op_e      op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [IMM_W-1:0]  imm,
  input  logic [SH_W-1:0]   shamt,
  output logic [DATA_W-1:0] y
);
  import exu_pkg::*;

  function automatic logic [DATA_W-1:0] alu_eval(
    input op_e               f,
    input logic [DATA_W-1:0] x,
    input logic [DATA_W-1:0] z,
    input logic [IMM_W-1:0]  k,
    input logic [SH_W-1:0]   s
  );
    case (f)
      OP_ADD, OP_ADDI: return x + z;
      OP_SUB:          return x - z;
      OP_AND, OP_ANDI: return x & z;
      OP_OR,  OP_ORI:  return x | z;
      OP_NOR:          return ~(x | z);
      OP_XOR, OP_XORI: return x ^ z;
      OP_SLL:          return x << s;
      OP_SRL:          return x >> s;
      OP_LUI:          return {k, {(DATA_W-IMM_W){1'b0}}};
      default:         return '0;
    endcase
  endfunction

  assign y = alu_eval(op, a, b, imm, shamt);

endmodule

// File: rtl/int_logic_exu.sv
module int_logic_exu #(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 32,
  parameter int IMM_W    = 16,
  localparam int IDX_W   = $clog2(NUM_REGS),
  localparam int SH_W    = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [3:0]        op_code,
  input  logic [IDX_W-1:0]  dst_idx,
  input  logic [IDX_W-1:0]  src_a_idx,
  input  logic [IDX_W-1:0]  src_b_idx,
  input  logic [IMM_W-1:0]  imm16,
  input  logic [SH_W-1:0]   shamt,
  output logic [DATA_W-1:0] result
);
  import exu_pkg::*;

  op_e               op;
  logic              op_legal;
  logic [IDX_W-1:0]  rd_idx [2];
  logic [DATA_W-1:0] rd_val [2];
  logic [DATA_W-1:0] opnd_a;
  logic [DATA_W-1:0] opnd_b;
  logic [DATA_W-1:0] alu_y;
  // Named write-back events, observed by the checker.
  logic              wb_commit;
  logic [IDX_W-1:0]  wb_idx;
  logic [DATA_W-1:0] wb_data;

  assign op       = op_e'(op_code);
  assign op_legal = op_is_legal(op_code);
  assign rd_idx[0] = src_a_idx;
  assign rd_idx[1] = src_b_idx;
  assign opnd_a   = rd_val[0];

  exu_regfile #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_rf (
    .clk (clk),
    .rst (rst),
    .we  (wb_commit),
    .wa  (wb_idx),
    .wd  (wb_data),
    .ra  (rd_idx),
    .rd  (rd_val)
  );

  exu_operand #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opnd (
    .op     (op),
    .src_b  (rd_val[1]),
    .imm    (imm16),
    .opnd_b (opnd_b)
  );

  exu_alu #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_alu (
    .op    (op),
    .a     (opnd_a),
    .b     (opnd_b),
    .imm   (imm16),
    .shamt (shamt),
    .y     (alu_y)
  );

  assign result    = op_legal ? alu_y : '0;
  assign wb_idx    = dst_idx;
  assign wb_data   = result;
  assign wb_commit = wr_en && op_legal && (dst_idx != '0) && !rst;

endmodule

// File: rtl/exu_checker.sv
module exu_checker #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 5,
  parameter int SH_W   = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [3:0]        op_code,
  input logic [SH_W-1:0]   shamt,
  input logic [IDX_W-1:0]  src_a_idx,
  input logic [DATA_W-1:0] rd_a,
  input logic [DATA_W-1:0] result,
  input logic              wb_commit,
  input logic [IDX_W-1:0]  wb_idx,
  input logic [DATA_W-1:0] wb_data
);

  p_zero_read_r2: assert property (@(posedge clk) disable iff (rst)
    (src_a_idx == '0) |-> (rd_a == '0));

  p_no_zero_write_r2: assert property (@(posedge clk) disable iff (rst)
    wb_commit |-> (wb_idx != '0));

  p_wr_gate_r9: assert property (@(posedge clk) disable iff (rst)
    !wr_en |-> !wb_commit);

  p_reserved_r11: assert property (@(posedge clk) disable iff (rst)
    (op_code > 4'd12) |-> (result == '0 && !wb_commit));

  p_upper_low_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (op_code == 4'd12) |-> (result[15:0] == 16'h0));

  p_sll_fill_r7: assert property (@(posedge clk) disable iff (rst)
    (op_code == 4'd10) |-> ((result & ~({DATA_W{1'b1}} << shamt)) == '0));

  p_srl_fill_r7: assert property (@(posedge clk) disable iff (rst)
    (op_code == 4'd11) |-> ((result & ~({DATA_W{1'b1}} >> shamt)) == '0));

  p_writeback_r10: assert property (@(posedge clk) disable iff (rst)
    ($past(wb_commit) && src_a_idx == $past(wb_idx)) |-> (rd_a == $past(wb_data)));

endmodule

bind int_logic_exu exu_checker #(.DATA_W(DATA_W), .IDX_W(IDX_W), .SH_W(SH_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .op_code   (op_code),
  .shamt     (shamt),
  .src_a_idx (src_a_idx),
  .rd_a      (opnd_a),
  .result    (result),
  .wb_commit (wb_commit),
  .wb_idx    (wb_idx),
  .wb_data   (wb_data)
);

// File: tb/tb_int_logic_exu.sv
module tb_int_logic_exu;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  op_code = '0;
  logic [4:0]  dst_idx = '0, src_a_idx = '0, src_b_idx = '0;
  logic [15:0] imm16 = '0;
  logic [4:0]  shamt = '0;
  logic [31:0] result;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  int_logic_exu dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .op_code(op_code),
    .dst_idx(dst_idx), .src_a_idx(src_a_idx), .src_b_idx(src_b_idx),
    .imm16(imm16), .shamt(shamt), .result(result)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic        we;
    logic [3:0]  op;
    logic [4:0]  rd;
    logic [4:0]  rs;
    logic [4:0]  rt;
    logic [15:0] imm;
    logic [4:0]  sh;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 30;
  // Expected results derived by hand from the requirements.
  localparam vec_t VEC [NV] = '{
    '{4'd8,  1'b1, 4'd12, 5'd1,  5'd0,  5'd0,  16'hAAAA, 5'd0,  32'hAAAA0000}, // R8 upper load
    '{4'd8,  1'b1, 4'd8,  5'd1,  5'd1,  5'd0,  16'hF0F0, 5'd0,  32'hAAAAF0F0}, // R8 complete constant
    '{4'd4,  1'b1, 4'd2,  5'd2,  5'd0,  5'd0,  16'hFFFF, 5'd0,  32'hFFFFFFFF}, // R4 -1
    '{4'd4,  1'b1, 4'd2,  5'd3,  5'd0,  5'd0,  16'h7FFF, 5'd0,  32'h00007FFF}, // R4 max positive
    '{4'd3,  1'b1, 4'd0,  5'd4,  5'd3,  5'd2,  16'h0,    5'd0,  32'h00007FFE}, // R3 add wrap
    '{4'd3,  1'b1, 4'd1,  5'd5,  5'd0,  5'd3,  16'h0,    5'd0,  32'hFFFF8001}, // R3 0 - x
    '{4'd3,  1'b1, 4'd1,  5'd6,  5'd3,  5'd0,  16'h0,    5'd0,  32'h00007FFF}, // R3 operand order
    '{4'd3,  1'b1, 4'd0,  5'd7,  5'd2,  5'd2,  16'h0,    5'd0,  32'hFFFFFFFE}, // R3 wrap
    '{4'd5,  1'b1, 4'd5,  5'd8,  5'd1,  5'd0,  16'h0,    5'd0,  32'h55550F0F}, // R5 NOR invert
    '{4'd5,  1'b1, 4'd6,  5'd9,  5'd1,  5'd2,  16'h0,    5'd0,  32'h55550F0F}, // R5 XOR invert
    '{4'd5,  1'b1, 4'd3,  5'd10, 5'd1,  5'd3,  16'h0,    5'd0,  32'h000070F0}, // R5 AND
    '{4'd5,  1'b1, 4'd4,  5'd11, 5'd3,  5'd8,  16'h0,    5'd0,  32'h55557FFF}, // R5 OR
    '{4'd6,  1'b1, 4'd7,  5'd12, 5'd2,  5'd0,  16'h8001, 5'd0,  32'h00008001}, // R6 ANDI zero-ext
    '{4'd6,  1'b1, 4'd9,  5'd13, 5'd2,  5'd0,  16'h8000, 5'd0,  32'hFFFF7FFF}, // R6 XORI
    '{4'd6,  1'b1, 4'd8,  5'd14, 5'd0,  5'd0,  16'h8000, 5'd0,  32'h00008000}, // R6 ORI
    '{4'd7,  1'b1, 4'd10, 5'd15, 5'd1,  5'd0,  16'h0,    5'd4,  32'hAAAF0F00}, // R7 SLL 4
    '{4'd7,  1'b1, 4'd11, 5'd16, 5'd1,  5'd0,  16'h0,    5'd4,  32'h0AAAAF0F}, // R7 SRL 4
    '{4'd7,  1'b1, 4'd10, 5'd17, 5'd2,  5'd0,  16'h0,    5'd31, 32'h80000000}, // R7 SLL 31
    '{4'd7,  1'b1, 4'd11, 5'd18, 5'd2,  5'd0,  16'h0,    5'd31, 32'h00000001}, // R7 SRL 31
    '{4'd7,  1'b1, 4'd10, 5'd19, 5'd1,  5'd0,  16'h0,    5'd0,  32'hAAAAF0F0}, // R7 shift 0
    '{4'd4,  1'b1, 4'd2,  5'd20, 5'd3,  5'd0,  16'h8000, 5'd0,  32'hFFFFFFFF}, // R4 -32768
    '{4'd2,  1'b1, 4'd0,  5'd0,  5'd2,  5'd2,  16'h0,    5'd0,  32'hFFFFFFFE}, // R2 write to 0
    '{4'd2,  1'b1, 4'd4,  5'd21, 5'd0,  5'd0,  16'h0,    5'd0,  32'h00000000}, // R2 reads zero
    '{4'd9,  1'b0, 4'd0,  5'd1,  5'd2,  5'd2,  16'h0,    5'd0,  32'hFFFFFFFE}, // R9 disabled
    '{4'd9,  1'b1, 4'd4,  5'd23, 5'd1,  5'd0,  16'h0,    5'd0,  32'hAAAAF0F0}, // R9 r1 kept
    '{4'd4,  1'b1, 4'd2,  5'd24, 5'd0,  5'd0,  16'h0005, 5'd0,  32'h00000005}, // R4 +5
    '{4'd11, 1'b1, 4'd15, 5'd24, 5'd2,  5'd2,  16'hFFFF, 5'd0,  32'h00000000}, // R11 reserved
    '{4'd11, 1'b1, 4'd4,  5'd25, 5'd24, 5'd0,  16'h0,    5'd0,  32'h00000005}, // R11 r24 kept
    '{4'd10, 1'b1, 4'd2,  5'd3,  5'd3,  5'd0,  16'h0001, 5'd0,  32'h00008000}, // R10 old value
    '{4'd10, 1'b1, 4'd4,  5'd26, 5'd3,  5'd0,  16'h0,    5'd0,  32'h00008000}  // R10 new value
  };

  task automatic exec(input vec_t v, input string tag);
    @(negedge clk);
    wr_en = v.we; op_code = v.op; dst_idx = v.rd; src_a_idx = v.rs;
    src_b_idx = v.rt; imm16 = v.imm; shamt = v.sh;
    #2;
    checks++;
    if (result !== v.exp) begin
      failures++;
      $display("FAIL R%0d %s: result=%h expected=%h", v.req, tag, result, v.exp);
    end
  endtask

  function automatic vec_t rd_reg(input logic [3:0] req, input logic [4:0] r);
    // OR r with register 0 into r27, expected zero
    return '{req, 1'b1, 4'd4, 5'd27, r, 5'd0, 16'h0, 5'd0, 32'h0};
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    // R1: registers read zero after reset
    exec(rd_reg(4'd1, 5'd1), "R1 after reset r1");
    exec(rd_reg(4'd1, 5'd31), "R1 after reset r31");
    for (int i = 0; i < NV; i++) exec(VEC[i], $sformatf("vector %0d", i));
    // R1: reset mid-run clears written registers
    @(negedge clk); wr_en = 1'b0; rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    exec(rd_reg(4'd1, 5'd1), "R1 reset clears r1");
    exec(rd_reg(4'd1, 5'd24), "R1 reset clears r24");
    exec(rd_reg(4'd1, 5'd27), "R1 reset clears r27");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule